// File: doc/BRIEF.md
# Segment-Control Address Translator

This block classifies and translates 32-bit virtual addresses under a programmable segment-control scheme. The address space is cut into six regions. Two of them cover the low 2 GiB, split at 0x4000_0000. The other four cover the upper 2 GiB in 512 MiB steps. Each region is described by a 16-bit configuration half-word taken from one of three 32-bit control inputs.

A half-word holds a 3-bit access-mode code, an error-unmapped flag and a 7-bit physical-base field. For each valid request the block crosses the region's access-mode code with the current privilege level. It then reports exactly one outcome: an address error, a request for a TLB lookup, or a direct unmapped translation. An unmapped translation carries a computed physical address and full read/write/execute permission.

The TLB itself lies outside the block. A core's address-generation stage drives the block and forwards TLB requests to a separate lookup unit.

Top module: `seg_xlate`

## Requirements
- R1: A virtual address below 0x4000_0000 takes its configuration from bits [31:16] of `segcfg2_i`. An address in 0x4000_0000..0x7FFF_FFFF takes its configuration from bits [15:0] of `segcfg2_i`.
- R2: Addresses starting at 0x8000_0000 take their configuration from `segcfg1_i[31:16]`. Addresses from 0xA000_0000 use `segcfg1_i[15:0]`. Addresses from 0xC000_0000 use `segcfg0_i[31:16]`. Addresses from 0xE000_0000 use `segcfg0_i[15:0]`.
- R3: Within a 16-bit configuration, bits [6:4] hold the access-mode code, bit 3 holds the error-unmapped flag and bits [15:9] hold the physical-base field. All other bits are ignored.
- R4: On an unmapped outcome, `paddr_o` is formed in two steps. First, the base field is placed at physical bits [35:29] and the bits covered by the region mask are cleared. Second, this value is ORed with the virtual address ANDed with the mask. The mask is 0x3FFF_FFFF below 0x8000_0000 and 0x1FFF_FFFF elsewhere.
- R5: Kernel privilege (`priv_i`=0) never faults, apart from the reserved code in R9. It requests a TLB lookup for access modes 1, 2 and 3 and is unmapped for modes 0, 4, 5 and 7.
- R6: Supervisor privilege (`priv_i`=1) faults for modes 0 and 1. It requests a TLB lookup for modes 2, 3 and 4 and is unmapped for modes 5 and 7.
- R7: User privilege (`priv_i`=2) faults for modes 0, 1, 2 and 5. It requests a TLB lookup for modes 3 and 4 and is unmapped for mode 7.
- R8: Error-level privilege (`priv_i`=3) gives an unmapped outcome whenever the segment's error-unmapped flag is set. Otherwise it behaves exactly as kernel privilege.
- R9: Access mode 6 is reserved and produces an address error at every privilege level, even when the error-unmapped flag is set.
- R10: `perm_rwx_o` is 3'b111 with an unmapped outcome and 3'b000 in every other case.
- R11: Results appear one clock after `req_valid_i`, together with `res_valid_o`. Exactly one of `addr_err_o`, `tlb_req_o` and `unmapped_o` is high with `res_valid_o`. All three are low while `res_valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Translation request strobe |
| vaddr_i | input | 32 | Virtual address |
| priv_i | input | 2 | Privilege: 0 kernel, 1 supervisor, 2 user, 3 error-level |
| segcfg0_i | input | 32 | Configurations for the two highest regions |
| segcfg1_i | input | 32 | Configurations for the 0x8000_0000 and 0xA000_0000 regions |
| segcfg2_i | input | 32 | Configurations for the two low regions |
| res_valid_o | output | 1 | Result valid |
| paddr_o | output | 36 | Physical address (meaningful with an unmapped outcome) |
| perm_rwx_o | output | 3 | Read/write/execute permission |
| tlb_req_o | output | 1 | Outcome: TLB lookup needed |
| addr_err_o | output | 1 | Outcome: address error |
| unmapped_o | output | 1 | Outcome: direct unmapped translation |

## Verification
Every output comes from a single register stage, so all results for a request are due on the first rising edge after the request is presented. The bench drives a request on a falling edge and checks the registered outputs on the following falling edge. Requests are issued back to back, so every cycle both checks the previous request and presents the next one. The sweep covers every combination of region, privilege, access mode and flag value. Idle cycles are checked for silent outcome flags on the same falling-edge schedule.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;
  localparam int CFG_W    = 16;
  localparam int AM_LSB   = 4;
  localparam int AM_W     = 3;
  localparam int EU_BIT   = 3;
  localparam int BASE_LSB = 9;
  localparam int BASE_W   = 7;
  localparam logic [AM_W-1:0] AM_RSVD = 3'd6;

  typedef enum logic [1:0] {
    PRIV_KERN = 2'd0,
    PRIV_SUPV = 2'd1,
    PRIV_USER = 2'd2,
    PRIV_ERRL = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    OUT_UNMAP = 2'd0,
    OUT_TLB   = 2'd1,
    OUT_AERR  = 2'd2
  } outcome_e;

  typedef struct packed {
    logic [BASE_W-1:0] base;
    logic [AM_W-1:0]   am;
    logic              eu;
  } seg_cfg_t;
endpackage

// File: rtl/seg_cfg_sel.sv
module seg_cfg_sel
  import seg_xlate_pkg::*;
#(
  parameter int VA_W = 32
) (
  input  logic [VA_W-1:0] vaddr_i,
  input  logic [31:0]     segcfg0_i,
  input  logic [31:0]     segcfg1_i,
  input  logic [31:0]     segcfg2_i,
  output seg_cfg_t        cfg_o,
  output logic            user_o
);
  localparam int N_SLOT = 8;
  localparam int SLOT_W = $clog2(N_SLOT);

  logic [2:0][31:0]        regs;
  logic [N_SLOT-1:0][CFG_W-1:0] slot_cfg;
  logic [CFG_W-1:0]        raw;

  assign regs = {segcfg2_i, segcfg1_i, segcfg0_i};

  // slots 0..3 cover user space (two per half), 4..7 the upper regions
  for (genvar g = 0; g < N_SLOT; g++) begin : g_slot
    localparam int RIDX = (g < 4) ? 2 : ((g < 6) ? 1 : 0);
    localparam bit HI   = (g < 4) ? (g < 2) : ((g % 2) == 0);
    if (HI) begin : g_hi
      assign slot_cfg[g] = regs[RIDX][31:16];
    end else begin : g_lo
      assign slot_cfg[g] = regs[RIDX][15:0];
    end
  end

  assign raw          = slot_cfg[vaddr_i[VA_W-1 -: SLOT_W]];
  assign cfg_o.base   = raw[BASE_LSB +: BASE_W];
  assign cfg_o.am     = raw[AM_LSB +: AM_W];
  assign cfg_o.eu     = raw[EU_BIT];
  assign user_o       = ~vaddr_i[VA_W-1];
endmodule

// File: rtl/seg_access_dec.sv
module seg_access_dec
  import seg_xlate_pkg::*;
(
  input  priv_e           priv_i,
  input  logic [AM_W-1:0] am_i,
  input  logic            eu_i,
  output outcome_e        out_o
);
  always_comb begin
    out_o = OUT_AERR;
    if (am_i == AM_RSVD) begin
      out_o = OUT_AERR;
    end else if (priv_i == PRIV_ERRL && eu_i) begin
      out_o = OUT_UNMAP;
    end else begin
      unique case (priv_i)
        PRIV_KERN, PRIV_ERRL: begin
          unique case (am_i)
            3'd1, 3'd2, 3'd3: out_o = OUT_TLB;
            default:          out_o = OUT_UNMAP;
          endcase
        end
        PRIV_SUPV: begin
          unique case (am_i)
            3'd0, 3'd1:       out_o = OUT_AERR;
            3'd2, 3'd3, 3'd4: out_o = OUT_TLB;
            default:          out_o = OUT_UNMAP;
          endcase
        end
        default: begin
          unique case (am_i)
            3'd3, 3'd4: out_o = OUT_TLB;
            3'd7:       out_o = OUT_UNMAP;
            default:    out_o = OUT_AERR;
          endcase
        end
      endcase
    end
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int PA_W        = 36,
  parameter int BASE_SHIFT  = 20,
  parameter int USER_OFF_W  = 30,
  parameter int KSEG_OFF_W  = 29
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  logic [31:0]     vaddr_i,
  input  logic [1:0]      priv_i,
  input  logic [31:0]     segcfg0_i,
  input  logic [31:0]     segcfg1_i,
  input  logic [31:0]     segcfg2_i,
  output logic            res_valid_o,
  output logic [PA_W-1:0] paddr_o,
  output logic [2:0]      perm_rwx_o,
  output logic            tlb_req_o,
  output logic            addr_err_o,
  output logic            unmapped_o
);
  localparam int VA_W = 32;
  localparam logic [PA_W-1:0] USER_MASK = (PA_W'(1) << USER_OFF_W) - PA_W'(1);
  localparam logic [PA_W-1:0] KSEG_MASK = (PA_W'(1) << KSEG_OFF_W) - PA_W'(1);
  localparam int BASE_POS = BASE_LSB + BASE_SHIFT;

  seg_cfg_t        cfg;
  logic            user_rgn;
  outcome_e        outc;
  logic [PA_W-1:0] mask;
  logic [PA_W-1:0] base_ext;
  logic [PA_W-1:0] pa_nxt;

  seg_cfg_sel #(.VA_W(VA_W)) u_sel (
    .vaddr_i   (vaddr_i),
    .segcfg0_i (segcfg0_i),
    .segcfg1_i (segcfg1_i),
    .segcfg2_i (segcfg2_i),
    .cfg_o     (cfg),
    .user_o    (user_rgn)
  );

  seg_access_dec u_dec (
    .priv_i (priv_e'(priv_i)),
    .am_i   (cfg.am),
    .eu_i   (cfg.eu),
    .out_o  (outc)
  );

  assign mask     = user_rgn ? USER_MASK : KSEG_MASK;
  assign base_ext = PA_W'(cfg.base) << BASE_POS;
  assign pa_nxt   = (base_ext & ~mask) | (PA_W'(vaddr_i) & mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      tlb_req_o   <= 1'b0;
      addr_err_o  <= 1'b0;
      unmapped_o  <= 1'b0;
      perm_rwx_o  <= '0;
      paddr_o     <= '0;
    end else begin
      res_valid_o <= req_valid_i;
      tlb_req_o   <= req_valid_i && (outc == OUT_TLB);
      addr_err_o  <= req_valid_i && (outc == OUT_AERR);
      unmapped_o  <= req_valid_i && (outc == OUT_UNMAP);
      perm_rwx_o  <= (req_valid_i && (outc == OUT_UNMAP)) ? 3'b111 : 3'b000;
      if (req_valid_i) paddr_o <= pa_nxt;
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int PA_W = 36
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic [31:0]     vaddr_i,
  input logic            res_valid_o,
  input logic [PA_W-1:0] paddr_o,
  input logic [2:0]      perm_rwx_o,
  input logic            tlb_req_o,
  input logic            addr_err_o,
  input logic            unmapped_o
);
  p_lat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o == $past(req_valid_i));

  p_onehot_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |-> $countones({tlb_req_o, addr_err_o, unmapped_o}) == 1);

  p_idle_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !res_valid_o |-> !(tlb_req_o || addr_err_o || unmapped_o));

  p_perm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> perm_rwx_o == 3'b111);

  p_noperm_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !unmapped_o |-> perm_rwx_o == 3'b000);

  p_offset_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unmapped_o |-> paddr_o[28:0] == $past(vaddr_i[28:0]));
endmodule

bind seg_xlate seg_xlate_chk #(.PA_W(PA_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .vaddr_i     (vaddr_i),
  .res_valid_o (res_valid_o),
  .paddr_o     (paddr_o),
  .perm_rwx_o  (perm_rwx_o),
  .tlb_req_o   (tlb_req_o),
  .addr_err_o  (addr_err_o),
  .unmapped_o  (unmapped_o)
);

// File: tb/seg_xlate_tb_top.sv
module seg_xlate_tb_top;
  localparam int PA_W = 36;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            req_valid_i;
  logic [31:0]     vaddr_i;
  logic [1:0]      priv_i;
  logic [31:0]     segcfg0_i, segcfg1_i, segcfg2_i;
  logic            res_valid_o;
  logic [PA_W-1:0] paddr_o;
  logic [2:0]      perm_rwx_o;
  logic            tlb_req_o, addr_err_o, unmapped_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #10 clk_i = ~clk_i;

  seg_xlate dut_i (.*);

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%s expected=%s", req, act, exp);
    end
  endtask

  // 0 unmapped, 1 tlb, 2 error
  function automatic int exp_out(input int pr, input int am, input bit eu);
    logic [7:0] err_m, tlb_m;
    if (am == 6) return 2;
    if (pr == 3 && eu) return 0;
    case (pr)
      1:       begin err_m = 8'h43; tlb_m = 8'h1C; end
      2:       begin err_m = 8'h67; tlb_m = 8'h18; end
      default: begin err_m = 8'h00; tlb_m = 8'h0E; end
    endcase
    if (err_m[am]) return 2;
    if (tlb_m[am]) return 1;
    return 0;
  endfunction

  function automatic logic [15:0] mk_cfg(input logic [6:0] base, input int am, input bit eu);
    // unused bits filled with ones to show they are ignored (R3)
    return {base, 2'b11, 3'(am), eu, 3'b111};
  endfunction

  function automatic string req_tag(input int pr, input int am);
    if (am == 6) return "R9";
    case (pr)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int iter = 0;
    rst_ni = 1'b0;
    req_valid_i = 1'b0;
    vaddr_i = '0;
    priv_i = '0;
    segcfg0_i = '0;
    segcfg1_i = '0;
    segcfg2_i = '0;
    repeat (3) @(negedge clk_i);
    chk(!res_valid_o && !tlb_req_o && !addr_err_o && !unmapped_o && perm_rwx_o == 3'b000,
        "R11 reset", $sformatf("%b%b%b%b", res_valid_o, tlb_req_o, addr_err_o, unmapped_o), "0000");
    rst_ni = 1'b1;
    @(negedge clk_i);

    for (int r = 0; r < 8; r++) begin
      for (int pr = 0; pr < 4; pr++) begin
        for (int am = 0; am < 8; am++) begin
          for (int e = 0; e < 2; e++) begin
            logic [15:0] hv [6];
            int          hidx;
            logic [6:0]  base;
            logic [31:0] va;
            logic [PA_W-1:0] msk, exp_pa;
            int          eo;
            string       tag;
            hidx = (r < 2) ? 0 : ((r < 4) ? 1 : r - 2);
            base = 7'(r * 17 + am * 5 + e + 1);
            for (int k = 0; k < 6; k++)
              hv[k] = (k == hidx) ? mk_cfg(base, am, e[0]) : mk_cfg(7'h55, 6, 1'b0);
            va = {3'(r), 29'(iter * 32'h0123_4567 + 32'h0ABC_DEF1)};
            segcfg2_i   = {hv[0], hv[1]};
            segcfg1_i   = {hv[2], hv[3]};
            segcfg0_i   = {hv[4], hv[5]};
            vaddr_i     = va;
            priv_i      = 2'(pr);
            req_valid_i = 1'b1;
            @(negedge clk_i);
            eo  = exp_out(pr, am, e[0]);
            tag = (r < 4) ? "R1" : "R2";
            msk = (r < 4) ? 36'h0_3FFF_FFFF : 36'h0_1FFF_FFFF;
            exp_pa = ({base, 29'b0} & ~msk) | ({4'b0, va} & msk);
            chk(res_valid_o && {tlb_req_o, addr_err_o, unmapped_o} ==
                  {eo == 1, eo == 2, eo == 0},
                $sformatf("%s %s r%0d p%0d am%0d eu%0d", req_tag(pr, am), tag, r, pr, am, e),
                $sformatf("v%b t%b e%b u%b", res_valid_o, tlb_req_o, addr_err_o, unmapped_o),
                $sformatf("v1 t%0d e%0d u%0d", eo == 1, eo == 2, eo == 0));
            chk(perm_rwx_o == ((eo == 0) ? 3'b111 : 3'b000), "R10",
                $sformatf("%b", perm_rwx_o), $sformatf("%b", (eo == 0) ? 3'b111 : 3'b000));
            if (eo == 0)
              chk(paddr_o == exp_pa, $sformatf("R4 R3 %s r%0d", tag, r),
                  $sformatf("%h", paddr_o), $sformatf("%h", exp_pa));
            iter++;
          end
        end
      end
    end

    req_valid_i = 1'b0;
    vaddr_i     = 32'hFFFF_FFFF;
    priv_i      = 2'd2;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      chk(!res_valid_o && !tlb_req_o && !addr_err_o && !unmapped_o && perm_rwx_o == 3'b000,
          "R11 idle", $sformatf("%b%b%b%b", res_valid_o, tlb_req_o, addr_err_o, unmapped_o), "0000");
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule